// File: doc/BRIEF.md
# Error-Masking FIR Filter with Low-Precision Shadow Path

This block is a streaming FIR filter that can tolerate timing faults in its arithmetic. A full-precision multiply-accumulate datapath produces the main result. Beside it runs a shadow datapath that sees the same samples and the same coefficients, but with the two least significant bits of each dropped. The shadow result is shifted back up to the scale of the main result, and a selector compares the two. A small difference comes from truncation and is expected, so the main result goes out unchanged. A difference above a fixed design-time threshold means the main result is treated as corrupted, and the shadow estimate goes out in its place. The output then loses some precision instead of being badly wrong.

Samples enter on `in_valid`/`in_sample`. Each accepted sample produces one filtered output three clocks later, once the tap window has been filled. A per-sample fault mask is carried down the pipeline with its sample and XORed onto the main sum before the comparison. This lets a test imitate a late-arriving result on the main path. Each output carries a flag that marks a substitution, and a saturating counter keeps a running total of substitutions.

A three-state machine manages how the window fills. `FILL_EMPTY` holds before any sample has arrived. The first accepted sample moves it to `FILL_PARTIAL`. It stays in `FILL_PARTIAL` while the window holds fewer than `NTAPS` samples, and moves to `FILL_STREAM` on the `NTAPS`-th accepted sample, which is the first sample that produces an output. `FILL_STREAM` holds until reset. A cycle with no input valid leaves the state and the window unchanged.

Top module: `rpr_fir_guard`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `out_valid`, `out_err` and `err_count` are all zero.
- R2: After reset, the first `NTAPS-1` accepted samples produce no output. The `NTAPS`-th accepted sample, and every accepted sample after it, produces exactly one output.
- R3: An accepted sample that produces an output makes `out_valid` high exactly three rising edges after the edge that accepted it. A cycle with `in_valid` low produces no output and does not move the window.
- R4: With a zero fault mask, `out_sample` equals sum over i of c(i)*x(n-i) exactly. Here x(n) is the newest sample and c(i) = ((53*i + 29) mod 255) - 127, an 8-bit signed value.
- R5: The shadow estimate equals 16 * sum over i of (x(n-i) >>> 2)*(c(i) >>> 2), where >>> is an arithmetic shift. It is the value driven on `out_sample` whenever `out_err` is high.
- R6: The fault mask that arrives with a sample is XORed, as an `ACC_W`-bit two's complement word, onto that sample's main sum. This happens before the comparison and before the output.
- R7: If |faulted main - shadow| > `THRESH` (default 4096), the shadow estimate is output and `out_err` is 1. Otherwise the faulted main sum is output and `out_err` is 0.
- R8: `err_count` goes up by one on each output with `out_err` high, and it stops at 2^`CNT_W`-1 (15 by default).
- R9: `out_err` is never high while `out_valid` is low.
- R10: An output whose fault mask is zero never has `out_err` set, for any input samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DW (8) | Signed input sample |
| fault_mask | input | ACC_W (18) | XOR mask carried with the sample onto its main sum |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | ACC_W (18) | Signed filtered output |
| out_err | output | 1 | Output was replaced by the shadow estimate |
| err_count | output | CNT_W (4) | Saturating count of replaced outputs |

## Verification
The assertions check, on every cycle, the relations that hold at any moment. The error flag never appears without a valid output. The count goes up by exactly one on each flagged output until it saturates. A flagged output carries the shadow sum from the previous pipeline stage. A sample without a fault mask is never flagged. The exact filter values, the fill behaviour of the state machine, the three-cycle latency across idle gaps, and the split between small faults that pass through and large faults that are masked depend on sample history. Only the bench's scenarios, compared against its behavioural model, can show those.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

    // Width of every filter coefficient.
    parameter int COEF_W = 8;

    // Fill tracking for the tap window.
    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PARTIAL = 2'd1,
        FILL_STREAM  = 2'd2
    } fill_state_e;

    // Coefficient of tap idx, generated instead of tabulated.
    function automatic logic signed [COEF_W-1:0] tap_coef(input int idx);
        int v;
        v = ((idx * 53 + 29) % 255) - 127;
        return COEF_W'(v);
    endfunction

endpackage

// File: rtl/rpr_window.sv
module rpr_window #(
    parameter int NTAPS = 4,
    parameter int DW    = 8,
    parameter int ACC_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [DW-1:0]    in_sample,
    input  logic [ACC_W-1:0]        in_fault,
    output logic signed [DW-1:0]    taps [NTAPS],
    output logic                    win_valid,
    output logic [ACC_W-1:0]        win_fault
);
    import rpr_pkg::*;

    localparam int FILL_W = $clog2(NTAPS) + 1;
    localparam logic [FILL_W-1:0] LAST_FILL = FILL_W'(NTAPS - 1);

    fill_state_e       state_q, state_d;
    logic [FILL_W-1:0] fill_q, fill_d;
    logic              emit;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // Next state and emit decision.
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        emit    = 1'b0;
        unique case (state_q)
            FILL_EMPTY: begin
                if (in_valid) begin
                    fill_d  = FILL_W'(1);
                    state_d = FILL_PARTIAL;
                end
            end
            FILL_PARTIAL: begin
                if (in_valid) begin
                    if (fill_q == LAST_FILL) begin
                        state_d = FILL_STREAM;
                        emit    = 1'b1;
                    end else begin
                        fill_d = fill_q + FILL_W'(1);
                    end
                end
            end
            FILL_STREAM: begin
                emit = in_valid;
            end
            default: begin
                state_d = FILL_EMPTY;
                fill_d  = '0;
            end
        endcase
    end

    // Delay line, newest sample in taps[0].
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAPS; i++) taps[i] <= '0;
        end else if (in_valid) begin
            taps[0] <= in_sample;
            for (int i = 1; i < NTAPS; i++) taps[i] <= taps[i-1];
        end
    end

    // Sideband travelling with the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_fault <= '0;
        end else begin
            win_valid <= emit;
            win_fault <= in_valid ? in_fault : '0;
        end
    end

endmodule

// File: rtl/rpr_mac.sv
module rpr_mac #(
    parameter int NTAPS = 4,
    parameter int DW    = 8,
    parameter int ACC_W = 18,
    parameter int TRUNC = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DW-1:0]     taps [NTAPS],
    output logic signed [ACC_W-1:0]  sum_q
);
    import rpr_pkg::*;

    localparam int XW    = DW - TRUNC;
    localparam int KW    = COEF_W - TRUNC;
    localparam int PW    = XW + KW;
    localparam int ALIGN = 2 * TRUNC;

    logic signed [PW-1:0]    prod [NTAPS];
    logic signed [ACC_W-1:0] acc;

    // One product per tap on the kept upper bits.
    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        localparam logic signed [COEF_W-1:0] CF = tap_coef(g);
        logic signed [XW-1:0] xs;
        logic signed [KW-1:0] ks;
        assign xs = $signed(taps[g][DW-1:TRUNC]);
        assign ks = $signed(CF[COEF_W-1:TRUNC]);
        assign prod[g] = PW'(xs) * PW'(ks);
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAPS; i++) acc = acc + ACC_W'(prod[i]);
    end

    // Registered sum, moved back to the full-precision scale.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= acc <<< ALIGN;
    end

endmodule

// File: rtl/rpr_select.sv
module rpr_select #(
    parameter int ACC_W  = 18,
    parameter int CNT_W  = 4,
    parameter int THRESH = 4096
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sum_valid,
    input  logic signed [ACC_W-1:0]  main_sum,
    input  logic signed [ACC_W-1:0]  rep_sum,
    input  logic [ACC_W-1:0]         fault,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_sample,
    output logic                     out_err,
    output logic [CNT_W-1:0]         err_count
);
    localparam logic [ACC_W:0]     LIMIT   = (ACC_W+1)'(THRESH);
    localparam logic [CNT_W-1:0]   CNT_MAX = '1;

    logic signed [ACC_W-1:0] hit_sum;
    logic signed [ACC_W:0]   diff;
    logic [ACC_W:0]          mag;
    logic                    mismatch;

    assign hit_sum  = main_sum ^ fault;
    assign diff     = {hit_sum[ACC_W-1], hit_sum} - {rep_sum[ACC_W-1], rep_sum};
    assign mag      = diff[ACC_W] ? (~diff + 1'b1) : diff;
    assign mismatch = mag > LIMIT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
            out_err    <= 1'b0;
        end else begin
            out_valid <= sum_valid;
            out_err   <= sum_valid && mismatch;
            if (sum_valid) out_sample <= mismatch ? rep_sum : hit_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                            err_count <= '0;
        else if (sum_valid && mismatch && err_count != CNT_MAX) err_count <= err_count + 1'b1;
    end

endmodule

// File: rtl/rpr_fir_guard.sv
module rpr_fir_guard #(
    parameter int NTAPS   = 4,
    parameter int DW      = 8,
    parameter int RW      = 6,
    parameter int CNT_W   = 4,
    parameter int THRESH  = 4096,
    localparam int ACC_W  = DW + rpr_pkg::COEF_W + $clog2(NTAPS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [DW-1:0]    in_sample,
    input  logic [ACC_W-1:0]        fault_mask,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_sample,
    output logic                    out_err,
    output logic [CNT_W-1:0]        err_count
);
    localparam int DROP = DW - RW;

    logic signed [DW-1:0]    taps [NTAPS];
    logic                    win_valid;
    logic [ACC_W-1:0]        win_fault;
    logic signed [ACC_W-1:0] main_sum_q;
    logic signed [ACC_W-1:0] rep_sum_q;
    logic                    valid_q2;
    logic [ACC_W-1:0]        fault_q2;

    rpr_window #(.NTAPS(NTAPS), .DW(DW), .ACC_W(ACC_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .in_fault  (fault_mask),
        .taps      (taps),
        .win_valid (win_valid),
        .win_fault (win_fault)
    );

    rpr_mac #(.NTAPS(NTAPS), .DW(DW), .ACC_W(ACC_W), .TRUNC(0)) u_main (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps),
        .sum_q (main_sum_q)
    );

    rpr_mac #(.NTAPS(NTAPS), .DW(DW), .ACC_W(ACC_W), .TRUNC(DROP)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps),
        .sum_q (rep_sum_q)
    );

    // Sideband aligned with the registered sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q2 <= 1'b0;
            fault_q2 <= '0;
        end else begin
            valid_q2 <= win_valid;
            fault_q2 <= win_fault;
        end
    end

    rpr_select #(.ACC_W(ACC_W), .CNT_W(CNT_W), .THRESH(THRESH)) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .sum_valid  (valid_q2),
        .main_sum   (main_sum_q),
        .rep_sum    (rep_sum_q),
        .fault      (fault_q2),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .out_err    (out_err),
        .err_count  (err_count)
    );

endmodule

// File: rtl/rpr_fir_guard_chk.sv
module rpr_fir_guard_chk #(
    parameter int ACC_W = 18,
    parameter int CNT_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [ACC_W-1:0] out_sample,
    input logic                    out_err,
    input logic [CNT_W-1:0]        err_count,
    input logic signed [ACC_W-1:0] rep_sum,
    input logic [ACC_W-1:0]        fault2
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R9
    err_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_err);

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err && $past(err_count) != CNT_MAX) |-> err_count == $past(err_count) + 1'b1);

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_err) |-> err_count == $past(err_count));

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

    // R5
    shadow_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> out_sample == $past(rep_sum));

    // R10
    clean_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(fault2) == '0) |-> !out_err);

endmodule

bind rpr_fir_guard rpr_fir_guard_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .out_err    (out_err),
    .err_count  (err_count),
    .rep_sum    (rep_sum_q),
    .fault2     (fault_q2)
);

// File: tb/test_rpr_fir_guard.sv
module test_rpr_fir_guard;
    localparam int NT    = 4;
    localparam int AW    = 18;
    localparam int THR   = 4096;
    localparam int CMAX  = 15;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [7:0]    in_sample = '0;
    logic [AW-1:0]        fault_mask = '0;
    logic                 out_valid;
    logic signed [AW-1:0] out_sample;
    logic                 out_err;
    logic [3:0]           err_count;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    rpr_fir_guard i_rpr_fir_guard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .fault_mask(fault_mask), .out_valid(out_valid), .out_sample(out_sample),
        .out_err(out_err), .err_count(err_count)
    );

    // Behavioural model state.
    int    win[$];
    int    hv[3], hd[3], he[3];
    int    exp_cnt = 0;
    string vtag = "R2";
    string dtag = "R4";
    string etag = "R10";

    function automatic int cf(int i);
        return ((i * 53 + 29) % 255) - 127;
    endfunction

    task automatic check(string tag, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // One clock: compare the entry pushed three steps ago, then drive.
    task automatic step(bit v, int x, logic [AW-1:0] f);
        int ev, ed, ee;
        @(negedge clk);
        check(vtag, int'(out_valid), hv[2]);
        if (hv[2] != 0) begin
            check(dtag, int'(out_sample), hd[2]);
            check(etag, int'(out_err), he[2]);
            if (he[2] != 0 && exp_cnt < CMAX) exp_cnt++;
        end else begin
            check("R9", int'(out_err), 0);
        end
        check("R8", int'(err_count), exp_cnt);
        hv[2] = hv[1]; hd[2] = hd[1]; he[2] = he[1];
        hv[1] = hv[0]; hd[1] = hd[0]; he[1] = he[0];
        ev = 0; ed = 0; ee = 0;
        if (v) begin
            win.push_front(x);
            if (win.size() > NT) void'(win.pop_back());
            if (win.size() == NT) begin
                int ex, rp, hit, dif;
                logic signed [AW-1:0] m;
                ex = 0; rp = 0;
                for (int i = 0; i < NT; i++) begin
                    ex += cf(i) * win[i];
                    rp += (win[i] >>> 2) * (cf(i) >>> 2);
                end
                rp = rp * 16;
                m = AW'(ex) ^ f;
                hit = int'(m);
                dif = hit - rp;
                if (dif < 0) dif = -dif;
                ev = 1;
                ee = (dif > THR) ? 1 : 0;
                ed = ee ? rp : hit;
            end
        end
        hv[0] = ev; hd[0] = ed; he[0] = ee;
        in_valid   = v;
        in_sample  = 8'(x);
        fault_mask = f;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin hv[i] = 0; hd[i] = 0; he[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs idle under reset
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_err), 0);
        check("R1", int'(err_count), 0);
        rst_n = 1'b1;
        // R2: first three samples fill the window, with a gap (R3)
        step(1, 100, '0);
        step(0, 0, '0);
        step(1, -128, '0);
        step(1, 127, '0);
        vtag = "R3";
        step(1, -77, '0);
        step(0, 0, '0);
        step(0, 0, '0);
        step(1, 5, '0);
        // R4 / R10: clean random stream with idle gaps
        for (int k = 0; k < 60; k++) begin
            step(($urandom_range(0, 3) != 0), int'($urandom_range(0, 255)) - 128, '0);
        end
        // R4: extreme values
        for (int k = 0; k < 8; k++) step(1, (k % 2 == 0) ? -128 : 127, '0);
        for (int k = 0; k < 6; k++) step(1, -128, '0);
        // R6: low-bit faults stay below threshold and pass through
        dtag = "R6"; etag = "R7";
        for (int k = 0; k < 10; k++) step(1, int'($urandom_range(0, 255)) - 128, AW'(1 << (k % 3)));
        // R5: large faults are masked by the shadow estimate
        dtag = "R5";
        for (int k = 0; k < 6; k++) step(1, int'($urandom_range(0, 255)) - 128, AW'(1 << 16));
        step(1, 33, AW'(1 << 17));
        // R8: drive the counter into saturation
        for (int k = 0; k < 14; k++) step(1, int'($urandom_range(0, 255)) - 128, AW'(3 << 15));
        // mixed clean and faulted
        dtag = "R4"; etag = "R10";
        for (int k = 0; k < 10; k++) step(1, int'($urandom_range(0, 255)) - 128, '0);
        for (int k = 0; k < 4; k++) step(0, 0, '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule